// File: doc/BRIEF.md
# Hierarchical Valid/Invalid Coherence Directory

This block is the home-node directory for one memory partition in a two-level multi-GPU machine of 4 GPUs with 4 modules each. For every line it serves, it keeps a single stable Valid/Invalid state and a sharer vector. The vector holds one bit per remote GPU and one bit per module of the home GPU. A remote GPU is therefore tracked as a whole, and a module of the home GPU is tracked on its own. Nothing records which module inside a remote GPU holds the copy.

Three request channels, write, read and eviction, carry a source GPU, a source module and a line index. Each channel has its own valid/ready handshake. At most one request is taken per cycle. Reads return a response and writes return a completion one cycle after acceptance. A write never waits for any acknowledgment, and the directory has no acknowledgment input and no transient state. The invalidations a write causes are placed as one sharer mask per write into a small queue. The queue then sends them one message at a time through a single valid/ready output. When the queue is full, every request channel is held off.

Top module: `hvi_directory`

## Requirements
- R1: After reset, all three request ready outputs are high with no request pending. rsp_valid, wdone_valid and inv_valid are all low.
- R2: When several channels are valid in one cycle, only one is accepted, in the order write, then read, then eviction. rd_ready is low while wr_valid is high. ev_ready is low while wr_valid or rd_valid is high.
- R3: A read accepted on one clock edge raises rsp_valid for one cycle after that edge, carrying the requester's GPU, module and line. The read records the requester as a sharer: its GPU bit if the GPU index is not HOME_GPU (default 0), otherwise its module bit.
- R4: A write accepted on one clock edge raises wdone_valid for one cycle after that edge, carrying the writer's GPU, module and line. This happens whether or not its invalidations have been delivered.
- R5: A write emits one invalidation for each sharer other than the writer, and afterwards only the writer remains a sharer. A remote GPU sharer is invalidated with inv_to_gpu=1, inv_gpu = that GPU and inv_mod=0. A home module sharer is invalidated with inv_to_gpu=0, inv_gpu=HOME_GPU and inv_mod = that module. Messages come out with remote GPUs first in ascending GPU index, then home modules in ascending module index.
- R6: Several modules of one remote GPU reading a line lead to exactly one invalidation for that GPU on a later write.
- R7: An eviction clears the evicting requester's sharer bit. Once no bit is left, the line is Invalid, and a later write to it emits no invalidation. An eviction from a requester that is not a sharer has no effect.
- R8: While inv_valid is high and inv_ready is low, the invalidation message stays unchanged.
- R9: When INV_DEPTH writes with invalidations are still pending in the queue, wr_ready, rd_ready and ev_ready are all low. Requests are taken again once the head entry has been fully sent.
- R10: Lines are independent: a request to one line never changes the sharers of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle if valid |
| wr_gpu | input | 2 | Writer GPU index |
| wr_mod | input | 2 | Writer module index |
| wr_line | input | 3 | Line index of the write |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| rd_gpu | input | 2 | Reader GPU index |
| rd_mod | input | 2 | Reader module index |
| rd_line | input | 3 | Line index of the read |
| ev_valid | input | 1 | Eviction notice present |
| ev_ready | output | 1 | Eviction accepted this cycle if valid |
| ev_gpu | input | 2 | Evicting GPU index |
| ev_mod | input | 2 | Evicting module index |
| ev_line | input | 3 | Line index of the eviction |
| rsp_valid | output | 1 | Read response pulse |
| rsp_gpu | output | 2 | Response destination GPU |
| rsp_mod | output | 2 | Response destination module |
| rsp_line | output | 3 | Response line |
| wdone_valid | output | 1 | Write completion pulse |
| wdone_gpu | output | 2 | Completion destination GPU |
| wdone_mod | output | 2 | Completion destination module |
| wdone_line | output | 3 | Completed line |
| inv_valid | output | 1 | Invalidation message present |
| inv_ready | input | 1 | Invalidation message taken |
| inv_to_gpu | output | 1 | 1: invalidate a whole remote GPU; 0: one home module |
| inv_gpu | output | 2 | Target GPU |
| inv_mod | output | 2 | Target module (0 when inv_to_gpu is 1) |
| inv_line | output | 3 | Line to invalidate |

## Verification
Two kinds of collision are provoked. In the first, a write, a read and an eviction are presented in the same cycle. The readies in that cycle, and which of the write completion or read response pulses appears on the following cycles, must follow the fixed write-read-eviction order. In the second, the invalidation drain meets new requests: inv_ready is held low until the queue fills. A further write must then see wr_ready low with the head message frozen. After inv_ready is released, the queue must drain, that write must be admitted, and its own invalidation must appear in order behind the older ones.

// File: rtl/hvi_pkg.sv
// Package: shared request encoding for the hierarchical VI directory.
// Assumes: exactly one request kind is active per cycle (chosen by the arbiter).
package hvi_pkg;
    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_READ  = 2'd2,
        REQ_EVICT = 2'd3
    } req_kind_e;
endpackage

// File: rtl/hvi_req_arbiter.sv
// Module: fixed-priority request arbiter (write > read > eviction).
// Assumes: 'hold' is high whenever the invalidation queue cannot take a new entry;
// all readies are then low.
module hvi_req_arbiter
    import hvi_pkg::*;
(
    input  logic      hold,
    input  logic      wr_valid,
    input  logic      rd_valid,
    input  logic      ev_valid,
    output logic      wr_ready,
    output logic      rd_ready,
    output logic      ev_ready,
    output req_kind_e kind
);
    // Readies: a lower-priority channel is ready only when no higher one is valid.
    always_comb begin
        wr_ready = !hold;
        rd_ready = !hold && !wr_valid;
        ev_ready = !hold && !wr_valid && !rd_valid;
    end

    // Accepted kind for this cycle.
    always_comb begin
        if (hold)          kind = REQ_NONE;
        else if (wr_valid) kind = REQ_WRITE;
        else if (rd_valid) kind = REQ_READ;
        else if (ev_valid) kind = REQ_EVICT;
        else               kind = REQ_NONE;
    end
endmodule

// File: rtl/hvi_dir_table.sv
// Module: per-line Valid/Invalid state and hierarchical sharer vectors.
// Sharer vector layout: bits [NUM_GPUS-1:0] one per GPU (home bit never set),
// bits [NUM_GPUS+MODS_PER_GPU-1:NUM_GPUS] one per module of the home GPU.
// Assumes: at most one request per cycle; writes commit at once, no acks.
module hvi_dir_table
    import hvi_pkg::*;
#(
    parameter int NUM_GPUS     = 4,
    parameter int MODS_PER_GPU = 4,
    parameter int NUM_LINES    = 8,
    parameter int HOME_GPU     = 0,
    localparam int SW     = NUM_GPUS + MODS_PER_GPU,
    localparam int GPU_W  = $clog2(NUM_GPUS),
    localparam int MOD_W  = $clog2(MODS_PER_GPU),
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_kind_e         kind,
    input  logic [GPU_W-1:0]  gpu,
    input  logic [MOD_W-1:0]  mod,
    input  logic [LINE_W-1:0] line,
    output logic              inv_push,
    output logic [SW-1:0]     inv_mask
);
    logic [SW-1:0]        sharers_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [SW-1:0]        cur;
    logic [SW-1:0]        req_bit;
    logic [SW-1:0]        nxt;
    logic                 upd;

    // Requester bit: whole GPU when remote, single module when on the home GPU.
    always_comb begin
        req_bit = '0;
        if (gpu == GPU_W'(HOME_GPU)) req_bit[NUM_GPUS + int'(mod)] = 1'b1;
        else                         req_bit[gpu] = 1'b1;
    end

    // Next sharer vector and invalidation mask for the accepted request.
    always_comb begin
        cur      = sharers_q[line];
        nxt      = cur;
        upd      = 1'b0;
        inv_mask = '0;
        inv_push = 1'b0;
        unique case (kind)
            REQ_READ: begin
                nxt = cur | req_bit;
                upd = 1'b1;
            end
            REQ_WRITE: begin
                nxt      = req_bit;
                upd      = 1'b1;
                inv_mask = cur & ~req_bit;
                inv_push = |(cur & ~req_bit);
            end
            REQ_EVICT: begin
                nxt = cur & ~req_bit;
                upd = valid_q[line];
            end
            default: ;
        endcase
    end

    // State update: line is Valid exactly while some sharer bit remains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) sharers_q[i] <= '0;
            valid_q <= '0;
        end else if (upd) begin
            sharers_q[line] <= nxt;
            valid_q[line]   <= |nxt;
        end
    end

    // R5: after a write, the line is Valid and holds exactly one sharer.
    p_write_single_sharer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REQ_WRITE) |=> (valid_q[$past(line)] && $onehot(sharers_q[$past(line)])));
    // R7: an eviction never adds sharers to its line.
    p_evict_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REQ_EVICT) |=> ((sharers_q[$past(line)] & ~$past(cur)) == '0));
endmodule

// File: rtl/hvi_inv_queue.sv
// Module: invalidation queue. Each entry is one write's sharer mask plus line;
// the head entry is sent one message per set bit, lowest bit first
// (remote GPUs ascending, then home modules ascending).
// Assumes: the producer never pushes while 'full' is high.
module hvi_inv_queue #(
    parameter int NUM_GPUS     = 4,
    parameter int MODS_PER_GPU = 4,
    parameter int NUM_LINES    = 8,
    parameter int HOME_GPU     = 0,
    parameter int DEPTH        = 2,
    localparam int SW     = NUM_GPUS + MODS_PER_GPU,
    localparam int SEL_W  = $clog2(SW),
    localparam int GPU_W  = $clog2(NUM_GPUS),
    localparam int MOD_W  = $clog2(MODS_PER_GPU),
    localparam int LINE_W = $clog2(NUM_LINES),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SW-1:0]     push_mask,
    input  logic [LINE_W-1:0] push_line,
    output logic              full,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic              inv_to_gpu,
    output logic [GPU_W-1:0]  inv_gpu,
    output logic [MOD_W-1:0]  inv_mod,
    output logic [LINE_W-1:0] inv_line
);
    logic [SW-1:0]     mask_q [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic [SW-1:0]     head;
    logic [SEL_W-1:0]  sel;
    logic              found;
    logic              take, pop;

    // Head entry and its lowest pending target.
    always_comb begin
        head  = mask_q[rd_ptr];
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < SW; i++) begin
            if (!found && head[i]) begin
                sel   = SEL_W'(i);
                found = 1'b1;
            end
        end
    end

    // Message decode and handshake bookkeeping.
    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        inv_valid  = (count != '0);
        inv_to_gpu = (int'(sel) < NUM_GPUS);
        inv_gpu    = inv_to_gpu ? GPU_W'(sel) : GPU_W'(HOME_GPU);
        inv_mod    = inv_to_gpu ? '0 : MOD_W'(int'(sel) - NUM_GPUS);
        inv_line   = line_q[rd_ptr];
        take       = inv_valid && inv_ready;
        pop        = take && ((head & ~(SW'(1) << sel)) == '0);
    end

    // Queue storage, pointers and per-message bit clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mask_q[i] <= '0;
                line_q[i] <= '0;
            end
        end else begin
            if (take) mask_q[rd_ptr][sel] <= 1'b0;
            if (push) begin
                mask_q[wr_ptr] <= push_mask;
                line_q[wr_ptr] <= push_line;
                wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R9: the producer is held off while the queue is full.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R8: a stalled message stays unchanged.
    p_inv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_gpu) && $stable(inv_mod)
                                       && $stable(inv_to_gpu) && $stable(inv_line)));
endmodule

// File: rtl/hvi_directory.sv
// Module: top of the hierarchical VI home directory. Arbitrates the write,
// read and eviction channels, updates the sharer table, pulses read responses
// and write completions one cycle after acceptance, and drains invalidations.
// Assumes: synchronous active-low reset; no acknowledgment path exists.
module hvi_directory
    import hvi_pkg::*;
#(
    parameter int NUM_GPUS     = 4,
    parameter int MODS_PER_GPU = 4,
    parameter int NUM_LINES    = 8,
    parameter int HOME_GPU     = 0,
    parameter int INV_DEPTH    = 2,
    localparam int SW     = NUM_GPUS + MODS_PER_GPU,
    localparam int GPU_W  = $clog2(NUM_GPUS),
    localparam int MOD_W  = $clog2(MODS_PER_GPU),
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [GPU_W-1:0]  wr_gpu,
    input  logic [MOD_W-1:0]  wr_mod,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [GPU_W-1:0]  rd_gpu,
    input  logic [MOD_W-1:0]  rd_mod,
    input  logic [LINE_W-1:0] rd_line,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [GPU_W-1:0]  ev_gpu,
    input  logic [MOD_W-1:0]  ev_mod,
    input  logic [LINE_W-1:0] ev_line,
    output logic              rsp_valid,
    output logic [GPU_W-1:0]  rsp_gpu,
    output logic [MOD_W-1:0]  rsp_mod,
    output logic [LINE_W-1:0] rsp_line,
    output logic              wdone_valid,
    output logic [GPU_W-1:0]  wdone_gpu,
    output logic [MOD_W-1:0]  wdone_mod,
    output logic [LINE_W-1:0] wdone_line,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic              inv_to_gpu,
    output logic [GPU_W-1:0]  inv_gpu,
    output logic [MOD_W-1:0]  inv_mod,
    output logic [LINE_W-1:0] inv_line
);
    req_kind_e         kind;
    logic              q_full;
    logic              q_push;
    logic [SW-1:0]     q_mask;
    logic [GPU_W-1:0]  sel_gpu;
    logic [MOD_W-1:0]  sel_mod;
    logic [LINE_W-1:0] sel_line;

    hvi_req_arbiter u_arb (
        .hold     (q_full),
        .wr_valid (wr_valid),
        .rd_valid (rd_valid),
        .ev_valid (ev_valid),
        .wr_ready (wr_ready),
        .rd_ready (rd_ready),
        .ev_ready (ev_ready),
        .kind     (kind)
    );

    // Fields of the accepted request.
    always_comb begin
        unique case (kind)
            REQ_WRITE: begin sel_gpu = wr_gpu; sel_mod = wr_mod; sel_line = wr_line; end
            REQ_READ:  begin sel_gpu = rd_gpu; sel_mod = rd_mod; sel_line = rd_line; end
            REQ_EVICT: begin sel_gpu = ev_gpu; sel_mod = ev_mod; sel_line = ev_line; end
            default:   begin sel_gpu = '0;     sel_mod = '0;     sel_line = '0;      end
        endcase
    end

    hvi_dir_table #(
        .NUM_GPUS(NUM_GPUS), .MODS_PER_GPU(MODS_PER_GPU),
        .NUM_LINES(NUM_LINES), .HOME_GPU(HOME_GPU)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .gpu      (sel_gpu),
        .mod      (sel_mod),
        .line     (sel_line),
        .inv_push (q_push),
        .inv_mask (q_mask)
    );

    hvi_inv_queue #(
        .NUM_GPUS(NUM_GPUS), .MODS_PER_GPU(MODS_PER_GPU),
        .NUM_LINES(NUM_LINES), .HOME_GPU(HOME_GPU), .DEPTH(INV_DEPTH)
    ) u_invq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_mask  (q_mask),
        .push_line  (sel_line),
        .full       (q_full),
        .inv_valid  (inv_valid),
        .inv_ready  (inv_ready),
        .inv_to_gpu (inv_to_gpu),
        .inv_gpu    (inv_gpu),
        .inv_mod    (inv_mod),
        .inv_line   (inv_line)
    );

    // Read-response and write-completion pulses, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            wdone_valid <= 1'b0;
            rsp_gpu     <= '0; rsp_mod   <= '0; rsp_line   <= '0;
            wdone_gpu   <= '0; wdone_mod <= '0; wdone_line <= '0;
        end else begin
            rsp_valid   <= (kind == REQ_READ);
            wdone_valid <= (kind == REQ_WRITE);
            if (kind == REQ_READ) begin
                rsp_gpu <= sel_gpu; rsp_mod <= sel_mod; rsp_line <= sel_line;
            end
            if (kind == REQ_WRITE) begin
                wdone_gpu <= sel_gpu; wdone_mod <= sel_mod; wdone_line <= sel_line;
            end
        end
    end

    // R2: a lower-priority channel is never taken beside a valid higher one.
    p_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_valid && rd_ready) |-> !wr_valid) and
        ((ev_valid && ev_ready) |-> (!wr_valid && !rd_valid)));
    // R3: accepted read is answered on the next cycle.
    p_read_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> (rsp_valid && rsp_line == $past(rd_line)
                                    && rsp_gpu == $past(rd_gpu) && rsp_mod == $past(rd_mod)));
    // R4: accepted write completes on the next cycle, ack-free.
    p_write_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (wdone_valid && wdone_line == $past(wr_line)));
    // R9: a full invalidation queue blocks every channel.
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> (!wr_ready && !rd_ready && !ev_ready));
endmodule

// File: tb/tb_hvi_directory.sv
`timescale 1ns/1ps
module tb_hvi_directory;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       wr_valid = 0, rd_valid = 0, ev_valid = 0, inv_ready = 0;
    logic [1:0] wr_gpu = 0, wr_mod = 0, rd_gpu = 0, rd_mod = 0, ev_gpu = 0, ev_mod = 0;
    logic [2:0] wr_line = 0, rd_line = 0, ev_line = 0;
    logic       wr_ready, rd_ready, ev_ready;
    logic       rsp_valid, wdone_valid, inv_valid, inv_to_gpu;
    logic [1:0] rsp_gpu, rsp_mod, wdone_gpu, wdone_mod, inv_gpu, inv_mod;
    logic [2:0] rsp_line, wdone_line, inv_line;

    int checks = 0;
    int fails  = 0;

    hvi_directory dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit rdy(input int k);
        return (k == 0) ? wr_ready : (k == 1) ? rd_ready : ev_ready;
    endfunction

    // Issue one request (k: 0 write, 1 read, 2 evict); returns at the
    // negedge right after the accepting clock edge.
    task automatic issue(input int k, input int g, input int m, input int l);
        @(negedge clk);
        case (k)
            0: begin wr_valid = 1; wr_gpu = 2'(g); wr_mod = 2'(m); wr_line = 3'(l); end
            1: begin rd_valid = 1; rd_gpu = 2'(g); rd_mod = 2'(m); rd_line = 3'(l); end
            default: begin ev_valid = 1; ev_gpu = 2'(g); ev_mod = 2'(m); ev_line = 3'(l); end
        endcase
        #1;
        while (!rdy(k)) begin @(negedge clk); #1; end
        @(negedge clk);
        wr_valid = 0; rd_valid = 0; ev_valid = 0;
    endtask

    // Check the current invalidation message, then let it be taken.
    task automatic expect_inv(input string tag, input int tog, input int g, input int m, input int l);
        chk(inv_valid, tag, int'(inv_valid), 1);
        chk(int'(inv_to_gpu) == tog && int'(inv_gpu) == g && int'(inv_mod) == m && int'(inv_line) == l,
            tag, {inv_to_gpu, inv_gpu, inv_mod, inv_line}, {tog[0], g[1:0], m[1:0], l[2:0]});
        @(negedge clk);
    endtask

    task automatic expect_no_inv(input string tag);
        chk(!inv_valid, tag, int'(inv_valid), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(wr_ready && rd_ready && ev_ready, "R1 readies", {wr_ready, rd_ready, ev_ready}, 7);
        chk(!rsp_valid && !wdone_valid && !inv_valid, "R1 outputs idle",
            {rsp_valid, wdone_valid, inv_valid}, 0);
    endtask

    task automatic t_read_resp;
        issue(1, 1, 3, 2);
        chk(rsp_valid && rsp_gpu == 1 && rsp_mod == 3 && rsp_line == 2, "R3 read response",
            {rsp_valid, rsp_gpu, rsp_mod, rsp_line}, {1'b1, 2'd1, 2'd3, 3'd2});
        @(negedge clk);
        chk(!rsp_valid, "R3 response single pulse", int'(rsp_valid), 0);
    endtask

    task automatic t_write_inv;
        inv_ready = 1;
        issue(1, 0, 1, 1); issue(1, 0, 2, 1); issue(1, 3, 0, 1);
        issue(1, 2, 1, 1); issue(1, 2, 3, 1);
        issue(0, 0, 1, 1);
        chk(wdone_valid && wdone_gpu == 0 && wdone_mod == 1 && wdone_line == 1, "R4 write done",
            {wdone_valid, wdone_gpu, wdone_mod, wdone_line}, {1'b1, 2'd0, 2'd1, 3'd1});
        expect_inv("R5 R6 first inv gpu2", 1, 2, 0, 1);
        expect_inv("R5 second inv gpu3", 1, 3, 0, 1);
        expect_inv("R5 third inv home mod2", 0, 0, 2, 1);
        expect_no_inv("R6 no duplicate gpu inv");
        issue(0, 3, 0, 1);
        expect_inv("R5 only writer kept", 0, 0, 1, 1);
        expect_no_inv("R5 nothing else");
        issue(0, 0, 0, 2);
        expect_inv("R10 line2 untouched by line1", 1, 1, 0, 2);
        expect_no_inv("R10 line2 single inv");
    endtask

    task automatic t_evict;
        issue(1, 0, 0, 3); issue(1, 1, 2, 3);
        issue(2, 0, 0, 3); issue(2, 1, 2, 3);
        issue(0, 2, 0, 3);
        chk(wdone_valid, "R7 write done on invalid line", int'(wdone_valid), 1);
        expect_no_inv("R7 invalid line no inv");
        @(negedge clk);
        expect_no_inv("R7 invalid line no inv later");
        issue(1, 0, 0, 7);
        issue(2, 0, 3, 7);
        issue(0, 1, 1, 7);
        expect_inv("R7 non-sharer evict ignored", 0, 0, 0, 7);
        expect_no_inv("R7 single inv");
    endtask

    task automatic t_priority;
        @(negedge clk);
        wr_valid = 1; wr_gpu = 1; wr_mod = 0; wr_line = 0;
        rd_valid = 1; rd_gpu = 0; rd_mod = 3; rd_line = 0;
        ev_valid = 1; ev_gpu = 0; ev_mod = 2; ev_line = 6;
        #1;
        chk(wr_ready && !rd_ready && !ev_ready, "R2 write wins",
            {wr_ready, rd_ready, ev_ready}, 4);
        @(negedge clk);
        chk(wdone_valid && !rsp_valid, "R2 write served first", {wdone_valid, rsp_valid}, 2);
        wr_valid = 0;
        #1;
        chk(rd_ready && !ev_ready, "R2 read before evict", {rd_ready, ev_ready}, 2);
        @(negedge clk);
        chk(rsp_valid && rsp_mod == 3 && !wdone_valid, "R2 read served second",
            {rsp_valid, rsp_mod, wdone_valid}, {1'b1, 2'd3, 1'b0});
        rd_valid = 0;
        #1;
        chk(ev_ready, "R2 evict served last", int'(ev_ready), 1);
        @(negedge clk);
        ev_valid = 0;
        expect_no_inv("R2 first write on clean line");
        issue(0, 0, 0, 0);
        expect_inv("R5 order remote first", 1, 1, 0, 0);
        expect_inv("R5 order then home module", 0, 0, 3, 0);
        expect_no_inv("R5 drained");
    endtask

    task automatic t_stall;
        logic [7:0] snap;
        inv_ready = 0;
        issue(1, 0, 2, 4); issue(1, 0, 2, 5); issue(1, 0, 2, 6);
        issue(0, 0, 0, 4); issue(0, 0, 0, 5);
        @(negedge clk);
        wr_valid = 1; wr_gpu = 0; wr_mod = 0; wr_line = 6;
        #1;
        chk(!wr_ready && !rd_ready && !ev_ready, "R9 full queue blocks",
            {wr_ready, rd_ready, ev_ready}, 0);
        snap = {inv_to_gpu, inv_gpu, inv_mod, inv_line};
        @(negedge clk); @(negedge clk);
        chk(inv_valid && {inv_to_gpu, inv_gpu, inv_mod, inv_line} == snap, "R8 message held",
            {inv_to_gpu, inv_gpu, inv_mod, inv_line}, snap);
        chk(snap == {1'b0, 2'd0, 2'd2, 3'd4}, "R8 head is line4 mod2", snap, {1'b0, 2'd0, 2'd2, 3'd4});
        chk(!wr_ready, "R9 still blocked", int'(wr_ready), 0);
        inv_ready = 1;
        #1;
        while (!wr_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        wr_valid = 0;
        chk(wdone_valid && wdone_line == 6, "R9 write admitted after drain",
            {wdone_valid, wdone_line}, {1'b1, 3'd6});
        expect_inv("R9 queued inv line6", 0, 0, 2, 6);
        expect_no_inv("R9 queue empty");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_read_resp;
        t_write_inv;
        t_evict;
        t_priority;
        t_stall;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule